// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 64-line direct-mapped data cache that sits between a processor load/store port and a word-wide backing memory. Each line holds a 16-byte block. Reads and writes that hit are served from the on-chip arrays. A write hit only changes the cached copy and marks the line dirty. On a miss the processor is held off and the line is replaced. If the victim line is dirty, its whole block is first written back to memory, one word per handshaked beat. Then the missing block is fetched the same way. A write miss allocates the line and merges the store into the fetched block.

The processor raises `cpu_req` for one cycle while `cpu_busy` is low. The cache captures the address, the direction and the write data at that clock edge. `cpu_busy` stays high until the access completes. Completion is signalled by a one-cycle pulse on `cpu_ack`, and for a read `cpu_rdata` is valid in that cycle. On a write acknowledge `cpu_rdata` keeps its previous value. The memory side has two channels. The fill channel holds a block-aligned request address while the cache waits for four incoming beats. The write-back channel offers four beats, each with its own address, under a valid/ready handshake.

Top module: `dm_wb_cache`

## Requirements
- R1: An address splits into tag = addr[31:10], line index = addr[9:4] and word select = addr[3:2]. addr[1:0] is ignored. An access hits only when the selected line is valid and its stored tag equals the address tag, all 22 bits of it. A read returns the word last written to that address, or the memory content if the word was never written.
- R2: A read or write hit raises `cpu_ack` for exactly one cycle. The pulse comes in the second cycle after the cycle in which the request was accepted. A hit causes no activity on either memory channel.
- R3: A write hit changes only the cached word and marks the line dirty. No write-back beat occurs at that time.
- R4: A miss on a line that is invalid or clean raises `mem_fill_req` with the block-aligned address {tag, index, 4'b0}. It takes exactly four fill beats, which land in word order 0 to 3. No write-back beat occurs.
- R5: A miss on a valid dirty line first sends the four victim words to the victim's own block addresses, in word order 0 to 3, with `mem_wb_last` high only on beat 3. All four beats complete before `mem_fill_req` is raised, and afterwards memory holds the victim's latest data.
- R6: A write miss fetches the block, and the store then replaces only the addressed word. The other three words keep their memory values, and the line ends dirty.
- R7: `cpu_busy` goes high in the cycle after a request is accepted. It stays high through every memory stall until the cycle of `cpu_ack`, and it is low in that cycle.
- R8: A synchronous active-high reset clears every valid and dirty bit. In the cycle after reset, `cpu_busy`, `cpu_ack`, `mem_fill_req` and `mem_wb_valid` are low. After reset, a line whose old tag still matches misses and is refilled with no write-back.
- R9: While `mem_wb_valid` is high and `mem_wb_ready` is low, the write-back address, data and last flag hold steady. The fill request and the write-back valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled while not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | Access in progress; processor must wait |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with a read acknowledge |
| mem_fill_req | output | 1 | Block refill requested |
| mem_fill_addr | output | 32 | Block-aligned refill address |
| mem_fill_valid | input | 1 | Refill beat present |
| mem_fill_data | input | 32 | Refill beat data |
| mem_wb_valid | output | 1 | Write-back beat offered |
| mem_wb_addr | output | 32 | Word address of the write-back beat |
| mem_wb_data | output | 32 | Write-back beat data |
| mem_wb_last | output | 1 | Final beat of the victim block |
| mem_wb_ready | input | 1 | Memory accepts the write-back beat |

## Verification
The access sequence steps through five cases on a few shared line indices: cold misses, read and write hits, clean-victim misses and dirty-victim misses. Each is told apart by its acknowledge latency, by the number of fill and write-back beats it causes, and by the victim address it sends. Re-reading a block after its dirty copy has been evicted shows that the written-back data really reached memory. Reading the untouched words of a block that was allocated by a write shows that the merge replaced one word only. The second half of the sequence adds gaps in the fill beats and deasserts the write-back ready, to exercise the handshake holds. The indices 0 and 63, an address that differs only in its top tag bit, and a reset that leaves a stale matching tag in place isolate the index, tag-width and valid-bit rules.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_REFILL,
    ST_FINISH
  } ctrl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_valid,
  output logic               rd_dirty,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               mark_en,
  input  logic [INDEX_W-1:0] mark_idx
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;

  // tag array has no reset so it can map onto plain RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic v_q;
    logic d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_en && fill_idx == INDEX_W'(g)) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
      end else if (mark_en && mark_idx == INDEX_W'(g)) begin
        d_q <= 1'b1;
      end
    end
    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_valid = valid_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int INDEX_W = 6,
  parameter int WSEL_W  = 2,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               we,
  input  logic [INDEX_W-1:0] w_line,
  input  logic [WSEL_W-1:0]  w_word,
  input  logic [WORD_W-1:0]  w_data,
  input  logic [INDEX_W-1:0] r_line,
  input  logic [WSEL_W-1:0]  r_word,
  output logic [WORD_W-1:0]  r_data
);
  localparam int DEPTH = 1 << (INDEX_W + WSEL_W);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_line, w_word}] <= w_data;
  end

  assign r_data = mem[{r_line, r_word}];
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int INDEX_W  = 6,
  parameter int OFFSET_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_ack,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_fill_req,
  output logic [ADDR_W-1:0] mem_fill_addr,
  input  logic              mem_fill_valid,
  input  logic [WORD_W-1:0] mem_fill_data,
  output logic              mem_wb_valid,
  output logic [ADDR_W-1:0] mem_wb_addr,
  output logic [WORD_W-1:0] mem_wb_data,
  output logic              mem_wb_last,
  input  logic              mem_wb_ready
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFFSET_W - BYTE_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;

  ctrl_state_t        state_q;
  logic [TAG_W-1:0]   req_tag;
  logic [INDEX_W-1:0] req_idx;
  logic [WSEL_W-1:0]  req_word;
  logic               req_we;
  logic [WORD_W-1:0]  req_wdata;
  logic [WSEL_W-1:0]  beat_q;

  logic [TAG_W-1:0]   st_tag;
  logic               st_valid;
  logic               st_dirty;
  logic               hit;
  logic               last_beat;

  logic               d_we;
  logic [WSEL_W-1:0]  d_wword;
  logic [WORD_W-1:0]  d_wdata;
  logic [WSEL_W-1:0]  d_rword;
  logic [WORD_W-1:0]  d_rdata;
  logic               mark_en;
  logic               fill_en;

  logic               unused_byte_bits;
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_tag   (st_tag),
    .rd_valid (st_valid),
    .rd_dirty (st_dirty),
    .fill_en  (fill_en),
    .fill_idx (req_idx),
    .fill_tag (req_tag),
    .mark_en  (mark_en),
    .mark_idx (req_idx)
  );

  dmc_data_store #(.INDEX_W(INDEX_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_data (
    .clk    (clk),
    .we     (d_we),
    .w_line (req_idx),
    .w_word (d_wword),
    .w_data (d_wdata),
    .r_line (req_idx),
    .r_word (d_rword),
    .r_data (d_rdata)
  );

  assign hit       = st_valid && (st_tag == req_tag);
  assign last_beat = (beat_q == {WSEL_W{1'b1}});

  // single write port shared by hit store, refill beats and merge
  always_comb begin
    d_we    = 1'b0;
    d_wword = req_word;
    d_wdata = req_wdata;
    unique case (state_q)
      ST_LOOKUP: d_we = hit && req_we;
      ST_REFILL: begin
        d_we    = mem_fill_valid;
        d_wword = beat_q;
        d_wdata = mem_fill_data;
      end
      ST_FINISH: d_we = req_we;
      default:   d_we = 1'b0;
    endcase
  end

  assign d_rword = (state_q == ST_EVICT) ? beat_q : req_word;
  assign mark_en = req_we && ((state_q == ST_LOOKUP && hit) || state_q == ST_FINISH);
  assign fill_en = (state_q == ST_REFILL) && mem_fill_valid && last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_word  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_idx   <= cpu_addr[OFFSET_W +: INDEX_W];
            req_word  <= cpu_addr[BYTE_W +: WSEL_W];
            req_we    <= cpu_we;
            req_wdata <= cpu_wdata;
            state_q   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (hit) begin
            if (!req_we) cpu_rdata <= d_rdata;
            cpu_ack <= 1'b1;
            state_q <= ST_IDLE;
          end else if (st_valid && st_dirty) begin
            state_q <= ST_EVICT;
          end else begin
            state_q <= ST_REFILL;
          end
        end
        ST_EVICT: begin
          if (mem_wb_ready) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_fill_valid) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          if (!req_we) cpu_rdata <= d_rdata;
          cpu_ack <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_busy      = (state_q != ST_IDLE);
  assign mem_fill_req  = (state_q == ST_REFILL);
  assign mem_fill_addr = {req_tag, req_idx, {OFFSET_W{1'b0}}};
  assign mem_wb_valid  = (state_q == ST_EVICT);
  assign mem_wb_addr   = {st_tag, req_idx, beat_q, {BYTE_W{1'b0}}};
  assign mem_wb_data   = d_rdata;
  assign mem_wb_last   = last_beat;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_busy,
  input logic              cpu_ack,
  input logic              mem_fill_req,
  input logic              mem_wb_valid,
  input logic              mem_wb_ready,
  input logic [ADDR_W-1:0] mem_wb_addr,
  input logic [WORD_W-1:0] mem_wb_data,
  input logic              mem_wb_last
);
  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wb_valid && !mem_wb_ready |=> mem_wb_valid && $stable(mem_wb_addr)
      && $stable(mem_wb_data) && $stable(mem_wb_last));

  // R9
  chan_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wb_valid && mem_fill_req));

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_busy |=> cpu_busy);

  // R7
  ack_free_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !cpu_busy);

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !cpu_busy && !cpu_ack && !mem_fill_req && !mem_wb_valid);
endmodule

bind dm_wb_cache dmc_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_req      (cpu_req),
  .cpu_busy     (cpu_busy),
  .cpu_ack      (cpu_ack),
  .mem_fill_req (mem_fill_req),
  .mem_wb_valid (mem_wb_valid),
  .mem_wb_ready (mem_wb_ready),
  .mem_wb_addr  (mem_wb_addr),
  .mem_wb_data  (mem_wb_data),
  .mem_wb_last  (mem_wb_last)
);

// File: tb/dm_wb_cache_test.sv
`timescale 1ns/1ps
module dm_wb_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_busy, cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_fill_req;
  logic [31:0] mem_fill_addr;
  logic        mem_fill_valid = 1'b0;
  logic [31:0] mem_fill_data = '0;
  logic        mem_wb_valid, mem_wb_last;
  logic [31:0] mem_wb_addr, mem_wb_data;
  logic        mem_wb_ready = 1'b0;

  always #2 clk = ~clk;

  dm_wb_cache uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_fill_req(mem_fill_req), .mem_fill_addr(mem_fill_addr), .mem_fill_valid(mem_fill_valid),
    .mem_fill_data(mem_fill_data), .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr),
    .mem_wb_data(mem_wb_data), .mem_wb_last(mem_wb_last), .mem_wb_ready(mem_wb_ready)
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] mem_model [1024];
  logic [31:0] golden    [1024];
  logic        sh_valid  [64];
  logic [21:0] sh_tag    [64];

  // responder bookkeeping
  int cyc = 0, fill_cnt = 0, fill_beats = 0, wb_beats = 0, wb_run = 0;
  int wb_before_fill = 0, order_bad = 0, hold_bad = 0;
  bit fill_seen = 0, hold_pending = 0, fill_gap = 0, wb_gap = 0;
  logic [31:0] fill_addr_seen = '0, wb_first_addr = '0, held_a = '0, held_d = '0;
  logic        held_l = 1'b0;

  function automatic logic [31:0] init_word(int i);
    return 32'h5A00_0000 | (i * 32'h0000_0107);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // memory responder, acting at falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (hold_pending) begin
        if (mem_wb_addr !== held_a || mem_wb_data !== held_d || mem_wb_last !== held_l)
          hold_bad++;
        hold_pending = 0;
      end
      if (mem_wb_valid) begin
        if (wb_gap && (cyc % 2 == 0)) begin
          mem_wb_ready = 1'b0;
          hold_pending = 1;
          held_a = mem_wb_addr; held_d = mem_wb_data; held_l = mem_wb_last;
        end else begin
          mem_wb_ready = 1'b1;
          if (wb_run == 0) wb_first_addr = mem_wb_addr;
          if (mem_wb_addr[3:2] != 2'(wb_run) || mem_wb_last != (wb_run % 4 == 3)) order_bad++;
          mem_model[mem_wb_addr[11:2]] = mem_wb_data;
          wb_run++;
          wb_beats++;
        end
      end else begin
        mem_wb_ready = 1'b0;
      end
      if (mem_fill_req) begin
        if (!fill_seen) begin
          fill_seen = 1;
          fill_addr_seen = mem_fill_addr;
          wb_before_fill = wb_run;
          wb_run = 0;
        end
        if (fill_cnt < 4 && !(fill_gap && (cyc % 3 == 0))) begin
          mem_fill_valid = 1'b1;
          mem_fill_data = mem_model[10'(mem_fill_addr[11:2] + fill_cnt)];
          fill_cnt++;
          fill_beats++;
        end else begin
          mem_fill_valid = 1'b0;
        end
      end else begin
        mem_fill_valid = 1'b0;
        fill_cnt = 0;
        fill_seen = 0;
      end
    end
  end

  // kind: 0 hit, 1 miss with invalid/clean victim, 2 miss with dirty victim
  task automatic access(int kind, bit we, logic [31:0] addr, logic [31:0] wd);
    int fb0 = fill_beats, wb0 = wb_beats, cycles = 0, busy_low = 0;
    int idx = int'(addr[9:4]);
    logic [31:0] victim = {sh_tag[idx], addr[9:4], 4'b0};
    wb_run = 0; order_bad = 0; hold_bad = 0; wb_before_fill = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    check(cpu_busy === 1'b1, "R7 busy after accept", {31'b0, cpu_busy}, 32'd1);
    while (cpu_ack !== 1'b1 && cycles < 400) begin
      if (cpu_busy !== 1'b1) busy_low++;
      @(negedge clk);
      cycles++;
    end
    check(busy_low == 0, "R7 busy held to ack", busy_low, 0);
    check(cpu_busy === 1'b0, "R7 idle at ack", {31'b0, cpu_busy}, 32'd0);
    if (we) golden[addr[11:2]] = wd;
    else check(cpu_rdata === golden[addr[11:2]], "R1 read data", cpu_rdata, golden[addr[11:2]]);
    case (kind)
      0: begin
        check(cycles == 1, "R2 hit latency", cycles, 1);
        check(fill_beats - fb0 == 0, "R2 no fill on hit", fill_beats - fb0, 0);
        check(wb_beats - wb0 == 0, "R3 no write-back on hit", wb_beats - wb0, 0);
      end
      1: begin
        check(fill_beats - fb0 == 4, "R4 fill beats", fill_beats - fb0, 4);
        check(wb_beats - wb0 == 0, "R4 no write-back", wb_beats - wb0, 0);
        check(fill_addr_seen === {addr[31:4], 4'b0}, "R4 fill address", fill_addr_seen, {addr[31:4], 4'b0});
      end
      default: begin
        check(wb_beats - wb0 == 4, "R5 write-back beats", wb_beats - wb0, 4);
        check(wb_before_fill == 4, "R5 write-back before fill", wb_before_fill, 4);
        check(wb_first_addr === victim, "R5 victim address", wb_first_addr, victim);
        check(order_bad == 0, "R5 beat order and last", order_bad, 0);
        check(hold_bad == 0, "R9 held beat", hold_bad, 0);
        check(fill_beats - fb0 == 4, "R4 fill beats after eviction", fill_beats - fb0, 4);
        for (int j = 0; j < 4; j++) begin
          int w = int'(victim[11:2]) + j;
          check(mem_model[w] === golden[w], "R5 memory holds victim data", mem_model[w], golden[w]);
        end
      end
    endcase
    sh_valid[idx] = 1'b1;
    sh_tag[idx] = addr[31:10];
  endtask

  localparam int NVEC = 17;
  // {kind[1:0], we, addr[31:0], wdata[31:0]}
  localparam logic [66:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 32'h0000_0010, 32'h0},
    {2'd0, 1'b0, 32'h0000_0018, 32'h0},
    {2'd0, 1'b1, 32'h0000_001C, 32'hDEAD_0003},
    {2'd0, 1'b0, 32'h0000_001C, 32'h0},
    {2'd2, 1'b0, 32'h0000_0410, 32'h0},
    {2'd1, 1'b0, 32'h0000_001C, 32'h0},
    {2'd1, 1'b1, 32'h0000_0854, 32'hBEEF_0007},
    {2'd0, 1'b0, 32'h0000_0854, 32'h0},
    {2'd0, 1'b0, 32'h0000_0850, 32'h0},
    {2'd2, 1'b1, 32'h0000_0C58, 32'hCAFE_000A},
    {2'd2, 1'b0, 32'h0000_0854, 32'h0},
    {2'd1, 1'b0, 32'h0000_0C58, 32'h0},
    {2'd1, 1'b1, 32'h0000_03FC, 32'h0BAD_F00D},
    {2'd1, 1'b0, 32'h0000_0000, 32'h0},
    {2'd0, 1'b0, 32'h0000_03FD, 32'h0},
    {2'd2, 1'b0, 32'h8000_03FC, 32'h0},
    {2'd0, 1'b1, 32'h8000_03F0, 32'h1234_5678}
  };

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_model[i] = init_word(i);
      golden[i] = init_word(i);
    end
    for (int i = 0; i < 64; i++) begin
      sh_valid[i] = 1'b0;
      sh_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    check(cpu_busy === 1'b0 && cpu_ack === 1'b0, "R8 reset cpu side", {30'b0, cpu_busy, cpu_ack}, 0);
    check(mem_fill_req === 1'b0 && mem_wb_valid === 1'b0, "R8 reset memory side",
          {30'b0, mem_fill_req, mem_wb_valid}, 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      fill_gap = (v >= 8);
      wb_gap = (v >= 8);
      access(int'(VEC[v][66:65]), VEC[v][64], VEC[v][63:32], VEC[v][31:0]);
    end

    // R6 write allocate merges one word only
    fill_gap = 0; wb_gap = 0;
    access(1, 1'b1, 32'h0000_0094, 32'hFACE_0001);
    access(0, 1'b0, 32'h0000_0090, 32'h0);
    check(cpu_rdata === init_word(36), "R6 untouched word after write miss", cpu_rdata, init_word(36));
    access(0, 1'b0, 32'h0000_0094, 32'h0);
    check(cpu_rdata === 32'hFACE_0001, "R6 merged word", cpu_rdata, 32'hFACE_0001);
    // R6 line ends dirty: evicting it writes back
    access(2, 1'b0, 32'h0000_0490, 32'h0);

    // R8 reset drops valid and dirty; stale matching tag still misses
    access(1, 1'b1, 32'h0000_0070, 32'h7777_0000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(cpu_busy === 1'b0 && mem_wb_valid === 1'b0, "R8 idle after reset",
          {30'b0, cpu_busy, mem_wb_valid}, 0);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) sh_valid[i] = 1'b0;
    for (int i = 0; i < 1024; i++) golden[i] = mem_model[i];
    access(1, 1'b0, 32'h0000_0070, 32'h0);
    check(cpu_rdata === init_word(28), "R8 dirty data dropped by reset", cpu_rdata, init_word(28));

    report();
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired R7 actual=hung expected=done");
    report();
    $finish;
  end
endmodule